// File: doc/BRIEF.md
# Per-Core Coherent Cache Line Agent

This block sits between one processor core and the coherence network of a multi-core system. It keeps a MESI state and a one-line data buffer for each of a small, fixed set of cache lines. It turns core loads, stores and evictions into protocol requests to the central directory, and it applies the directory's grants, refusals and acknowledgements to its lines. It also answers invalidations that the directory raises on behalf of other cores. Each line is addressed by its index, and that index is carried as the address field of every message.

At most one of the agent's own requests is in flight at a time. Transaction IDs come from a wrapping per-core counter. Invalidations are served at any time, including while the agent's own request is pending.

There are three streams. Core requests use a valid/ready handshake: `req_ready` is low while a request is outstanding, while an outbound message is waiting, while `rx_valid` is high, and for the line that has a forced writeback still unacknowledged. Outbound messages are held stable in a one-entry slot until `tx_ready` accepts them. Inbound messages are accepted only while that slot is empty, so `rx_ready` is low while an outbound message waits. Completions (`done_valid`) and `proto_err` are single-cycle pulses that have no back-pressure.

Top module: `coh_line_agent`

## Requirements
- R1: After reset every line is Invalid, `tx_valid`, `done_valid` and `proto_err` are 0, and `req_ready` and `rx_ready` are 1.
- R2: A load (`req_op`=0) to an Invalid line sends ReadShared (`tx_type`=0). GrantE (`rx_type`=0) fills the line as Exclusive and GrantS (`rx_type`=1) fills it as Shared, and completion returns the granted data. A load to a valid line completes with the buffered data and sends nothing.
- R3: A store (`req_op`=1) to an Invalid line sends ReadExclusive (`tx_type`=1). On GrantE the line becomes Modified and holds the store data, and the store completes.
- R4: A store to an Exclusive or Modified line writes the buffer, makes the line Modified and completes with no message.
- R5: A store to a Shared line sends Upgrade (`tx_type`=2). GrantM (`rx_type`=2) makes the line Modified with the store data, and no data is taken from the grant.
- R6: An Invalidate (`rx_type`=4) for a line that is not Modified is answered by InvAck (`tx_type`=4) with the same transaction ID, and the line becomes Invalid.
- R7: An Invalidate for a Modified line is answered by WriteBack (`tx_type`=3) carrying the line data and the same transaction ID. The line becomes Invalid when WriteBackAck (`rx_type`=5) with that ID arrives; this produces no completion, and core requests to that line wait until then.
- R8: Evicting (`req_op`=2) a Modified line sends WriteBack with its data and a new own transaction ID. The line becomes Invalid and the eviction completes on the matching WriteBackAck.
- R9: Evicting a Shared, Exclusive or Invalid line makes it Invalid and completes at once with no message.
- R10: Nack (`rx_type`=3) to a pending Upgrade leaves the line Invalid and reissues the request as ReadExclusive with the next transaction ID. The store completes on the later GrantE.
- R11: An Invalidate that arrives while an Upgrade is pending is answered at once, and the Upgrade stays outstanding.
- R12: Every new own request takes the next value of a TXN_W-bit counter that starts at 0 and wraps.
- R13: A grant, Nack or WriteBackAck whose ID or line does not match an outstanding exchange causes a one-cycle `proto_err` pulse and changes no line.
- R14: An outbound message keeps `tx_valid` and all its fields stable until `tx_ready`. While it waits, `req_ready` and `rx_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted this cycle if valid |
| req_op | input | 2 | 0 load, 1 store, 2 evict (3 acts as evict) |
| req_line | input | $clog2(NUM_LINES) | Line index |
| req_wdata | input | DATA_W | Store data |
| done_valid | output | 1 | Core operation completed (pulse) |
| done_rdata | output | DATA_W | Load result; store data for stores; 0 for evictions |
| tx_valid | output | 1 | Outbound message valid |
| tx_ready | input | 1 | Network accepts outbound message |
| tx_type | output | 3 | 0 ReadShared, 1 ReadExclusive, 2 Upgrade, 3 WriteBack, 4 InvAck |
| tx_line | output | $clog2(NUM_LINES) | Line index of message |
| tx_txn | output | TXN_W | Transaction ID |
| tx_data | output | DATA_W | WriteBack data, else 0 |
| rx_valid | input | 1 | Inbound message valid |
| rx_ready | output | 1 | Inbound message accepted if valid |
| rx_type | input | 3 | 0 GrantE, 1 GrantS, 2 GrantM, 3 Nack, 4 Invalidate, 5 WriteBackAck |
| rx_line | input | $clog2(NUM_LINES) | Line index of message |
| rx_txn | input | TXN_W | Transaction ID |
| rx_data | input | DATA_W | Grant data |
| proto_err | output | 1 | Unmatched response seen (pulse) |

## Verification
On every cycle the assertions hold the outbound slot stable under back-pressure and check that the slot is never loaded while full. They check that the transaction counter moves exactly once per new request, that a clean line hit by an Invalidate is Invalid in the next cycle, and that a retry is entered only from a Nack. Completions and error pulses must trace back to an accepted request or message. Only the bench's scenarios show the message sequences end to end. These are the fill states seen through later hits and misses, the silent store upgrade, the forced and voluntary writebacks, the Nack-and-retry path with an Invalidate in between, counter wrap-around, and unmatched responses leaving the lines untouched.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_EVICT2 = 2'd3} core_op_t;
  typedef enum logic [2:0] {
    TX_RD_SHARED = 3'd0, TX_RD_EXCL = 3'd1, TX_UPGRADE = 3'd2,
    TX_WRITEBACK = 3'd3, TX_INV_ACK = 3'd4
  } tx_msg_t;
  typedef enum logic [2:0] {
    RX_GRANT_E = 3'd0, RX_GRANT_S = 3'd1, RX_GRANT_M = 3'd2,
    RX_NACK = 3'd3, RX_INVAL = 3'd4, RX_WB_ACK = 3'd5, RX_RSV6 = 3'd6, RX_RSV7 = 3'd7
  } rx_msg_t;
endpackage

// File: rtl/cla_txn_ctr.sv
module cla_txn_ctr #(
  parameter int TXN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  output logic [TXN_W-1:0] txn_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       txn_o <= '0;
    else if (alloc_i) txn_o <= txn_o + 1'b1;
  end

  AST_TXN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> txn_o == TXN_W'($past(txn_o) + 1'b1)); // R12
  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_i |=> $stable(txn_o)); // R12
endmodule

// File: rtl/cla_tx_slot.sv
module cla_tx_slot import cla_pkg::*; #(
  parameter int IDX_W  = 2,
  parameter int TXN_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  tx_msg_t           type_i,
  input  logic [IDX_W-1:0]  line_i,
  input  logic [TXN_W-1:0]  txn_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output tx_msg_t           type_o,
  output logic [IDX_W-1:0]  line_o,
  output logic [TXN_W-1:0]  txn_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      type_o  <= TX_RD_SHARED;
      line_o  <= '0;
      txn_o   <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      type_o  <= type_i;
      line_o  <= line_i;
      txn_o   <= txn_i;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(type_o) && $stable(line_o)
                               && $stable(txn_o) && $stable(data_o))); // R14
  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o); // R14
endmodule

// File: rtl/cla_line_array.sv
module cla_line_array import cla_pkg::*; #(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [$clog2(NUM_LINES)-1:0] widx_i,
  input  mesi_t                        wstate_i,
  input  logic                         wdata_en_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [$clog2(NUM_LINES)-1:0] ridx_a_i,
  output mesi_t                        rstate_a_o,
  output logic [DATA_W-1:0]            rdata_a_o,
  input  logic [$clog2(NUM_LINES)-1:0] ridx_b_i,
  output mesi_t                        rstate_b_o,
  output logic [DATA_W-1:0]            rdata_b_o,
  output mesi_t [NUM_LINES-1:0]        state_all_o
);
  logic [DATA_W-1:0] data_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_all_o[g] <= ST_I;
        data_q[g]      <= '0;
      end else if (we_i && widx_i == g) begin
        state_all_o[g] <= wstate_i;
        if (wdata_en_i) data_q[g] <= wdata_i;
      end
    end
  end

  assign rstate_a_o = state_all_o[ridx_a_i];
  assign rdata_a_o  = data_q[ridx_a_i];
  assign rstate_b_o = state_all_o[ridx_b_i];
  assign rdata_b_o  = data_q[ridx_b_i];
endmodule

// File: rtl/coh_line_agent.sv
module coh_line_agent import cla_pkg::*; #(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 32,
  parameter int TXN_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_op,
  input  logic [$clog2(NUM_LINES)-1:0] req_line,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         done_valid,
  output logic [DATA_W-1:0]            done_rdata,
  output logic                         tx_valid,
  input  logic                         tx_ready,
  output logic [2:0]                   tx_type,
  output logic [$clog2(NUM_LINES)-1:0] tx_line,
  output logic [TXN_W-1:0]             tx_txn,
  output logic [DATA_W-1:0]            tx_data,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic [2:0]                   rx_type,
  input  logic [$clog2(NUM_LINES)-1:0] rx_line,
  input  logic [TXN_W-1:0]             rx_txn,
  input  logic [DATA_W-1:0]            rx_data,
  output logic                         proto_err
);
  localparam int IDX_W = $clog2(NUM_LINES);

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_RETRY} fsm_t;

  fsm_t              fsm_q, fsm_d;
  core_op_t          pend_op_q;
  logic [IDX_W-1:0]  pend_line_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [TXN_W-1:0]  pend_txn_q;
  tx_msg_t           pend_msg_q;
  logic              fwb_q;
  logic [TXN_W-1:0]  fwb_txn_q;
  logic [IDX_W-1:0]  fwb_line_q;

  logic              slot_load, slot_busy, alloc;
  tx_msg_t           slot_type, slot_type_o;
  logic [IDX_W-1:0]  slot_line;
  logic [TXN_W-1:0]  slot_txn, txn_cur;
  logic [DATA_W-1:0] slot_data;
  logic              arr_we, arr_dwe;
  logic [IDX_W-1:0]  arr_idx;
  mesi_t             arr_state, st_a, st_b;
  logic [DATA_W-1:0] arr_data, dat_a, dat_b;
  mesi_t [NUM_LINES-1:0] st_all;
  logic              done_d, err_d, set_fwb, clr_fwb, rsp_match;
  logic [DATA_W-1:0] done_data_d;
  logic              req_fire, rx_fire;
  rx_msg_t           rx_kind;
  core_op_t          req_kind;

  assign rx_kind   = rx_msg_t'(rx_type);
  assign req_kind  = core_op_t'(req_op);
  assign rx_ready  = !slot_busy;
  assign rx_fire   = rx_valid && rx_ready;
  assign req_ready = (fsm_q == F_IDLE) && !slot_busy && !rx_valid &&
                     !(fwb_q && req_line == fwb_line_q);
  assign req_fire  = req_valid && req_ready;

  cla_txn_ctr #(.TXN_W(TXN_W)) u_txn (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .txn_o(txn_cur));

  cla_tx_slot #(.IDX_W(IDX_W), .TXN_W(TXN_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_i(slot_load), .type_i(slot_type),
    .line_i(slot_line), .txn_i(slot_txn), .data_i(slot_data),
    .valid_o(slot_busy), .ready_i(tx_ready), .type_o(slot_type_o),
    .line_o(tx_line), .txn_o(tx_txn), .data_o(tx_data));

  assign tx_valid = slot_busy;
  assign tx_type  = slot_type_o;

  cla_line_array #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .we_i(arr_we), .widx_i(arr_idx),
    .wstate_i(arr_state), .wdata_en_i(arr_dwe), .wdata_i(arr_data),
    .ridx_a_i(req_line), .rstate_a_o(st_a), .rdata_a_o(dat_a),
    .ridx_b_i(rx_line), .rstate_b_o(st_b), .rdata_b_o(dat_b),
    .state_all_o(st_all));

  always_comb begin
    slot_load   = 1'b0;
    slot_type   = TX_INV_ACK;
    slot_line   = rx_line;
    slot_txn    = rx_txn;
    slot_data   = '0;
    arr_we      = 1'b0;
    arr_idx     = pend_line_q;
    arr_state   = ST_I;
    arr_dwe     = 1'b0;
    arr_data    = rx_data;
    alloc       = 1'b0;
    fsm_d       = fsm_q;
    done_d      = 1'b0;
    done_data_d = '0;
    err_d       = 1'b0;
    set_fwb     = 1'b0;
    clr_fwb     = 1'b0;
    rsp_match   = (fsm_q == F_WAIT) && (rx_txn == pend_txn_q) && (rx_line == pend_line_q);
    if (rx_fire) begin
      case (rx_kind)
        RX_INVAL: begin
          slot_load = 1'b1;
          if (st_b == ST_M) begin
            slot_type = TX_WRITEBACK;
            slot_data = dat_b;
            set_fwb   = 1'b1;
          end else begin
            arr_we  = 1'b1;
            arr_idx = rx_line;
          end
        end
        RX_GRANT_E: begin
          if (rsp_match && (pend_msg_q == TX_RD_SHARED || pend_msg_q == TX_RD_EXCL)) begin
            arr_we  = 1'b1;
            arr_dwe = 1'b1;
            done_d  = 1'b1;
            fsm_d   = F_IDLE;
            if (pend_op_q == OP_STORE) begin
              arr_state   = ST_M;
              arr_data    = pend_data_q;
              done_data_d = pend_data_q;
            end else begin
              arr_state   = ST_E;
              done_data_d = rx_data;
            end
          end else err_d = 1'b1;
        end
        RX_GRANT_S: begin
          if (rsp_match && pend_msg_q == TX_RD_SHARED) begin
            arr_we      = 1'b1;
            arr_dwe     = 1'b1;
            arr_state   = ST_S;
            done_d      = 1'b1;
            done_data_d = rx_data;
            fsm_d       = F_IDLE;
          end else err_d = 1'b1;
        end
        RX_GRANT_M: begin
          if (rsp_match && pend_msg_q == TX_UPGRADE) begin
            arr_we      = 1'b1;
            arr_dwe     = 1'b1;
            arr_state   = ST_M;
            arr_data    = pend_data_q;
            done_d      = 1'b1;
            done_data_d = pend_data_q;
            fsm_d       = F_IDLE;
          end else err_d = 1'b1;
        end
        RX_NACK: begin
          if (rsp_match && pend_msg_q == TX_UPGRADE) begin
            arr_we = 1'b1;
            fsm_d  = F_RETRY;
          end else err_d = 1'b1;
        end
        RX_WB_ACK: begin
          if (fwb_q && rx_txn == fwb_txn_q && rx_line == fwb_line_q) begin
            arr_we  = 1'b1;
            arr_idx = fwb_line_q;
            clr_fwb = 1'b1;
          end else if (rsp_match && pend_msg_q == TX_WRITEBACK) begin
            arr_we = 1'b1;
            done_d = 1'b1;
            fsm_d  = F_IDLE;
          end else err_d = 1'b1;
        end
        default: err_d = 1'b1;
      endcase
    end else if (fsm_q == F_RETRY && !slot_busy) begin
      slot_load = 1'b1;
      slot_type = TX_RD_EXCL;
      slot_line = pend_line_q;
      slot_txn  = txn_cur;
      alloc     = 1'b1;
      fsm_d     = F_WAIT;
    end else if (req_fire) begin
      slot_line = req_line;
      slot_txn  = txn_cur;
      arr_idx   = req_line;
      case (req_kind)
        OP_LOAD: begin
          if (st_a != ST_I) begin
            done_d      = 1'b1;
            done_data_d = dat_a;
          end else begin
            slot_load = 1'b1;
            slot_type = TX_RD_SHARED;
          end
        end
        OP_STORE: begin
          if (st_a == ST_M || st_a == ST_E) begin
            arr_we      = 1'b1;
            arr_state   = ST_M;
            arr_dwe     = 1'b1;
            arr_data    = req_wdata;
            done_d      = 1'b1;
            done_data_d = req_wdata;
          end else begin
            slot_load = 1'b1;
            slot_type = (st_a == ST_S) ? TX_UPGRADE : TX_RD_EXCL;
          end
        end
        default: begin
          if (st_a == ST_M) begin
            slot_load = 1'b1;
            slot_type = TX_WRITEBACK;
            slot_data = dat_a;
          end else begin
            arr_we = (st_a != ST_I);
            done_d = 1'b1;
          end
        end
      endcase
      if (slot_load) begin
        alloc = 1'b1;
        fsm_d = F_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q       <= F_IDLE;
      pend_op_q   <= OP_LOAD;
      pend_line_q <= '0;
      pend_data_q <= '0;
      pend_txn_q  <= '0;
      pend_msg_q  <= TX_RD_SHARED;
      fwb_q       <= 1'b0;
      fwb_txn_q   <= '0;
      fwb_line_q  <= '0;
      done_valid  <= 1'b0;
      done_rdata  <= '0;
      proto_err   <= 1'b0;
    end else begin
      fsm_q      <= fsm_d;
      done_valid <= done_d;
      done_rdata <= done_data_d;
      proto_err  <= err_d;
      if (req_fire) begin
        pend_op_q   <= req_kind;
        pend_line_q <= req_line;
        pend_data_q <= req_wdata;
      end
      if (alloc) begin
        pend_txn_q <= txn_cur;
        pend_msg_q <= slot_type;
      end
      if (set_fwb) begin
        fwb_q      <= 1'b1;
        fwb_txn_q  <= rx_txn;
        fwb_line_q <= rx_line;
      end else if (clr_fwb) begin
        fwb_q <= 1'b0;
      end
    end
  end

  AST_ERR_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rx_valid && rx_ready)); // R13
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(req_fire || rx_fire)); // R2
  AST_INV_CLEAN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rx_kind == RX_INVAL && (st_b == ST_S || st_b == ST_E))
      |=> st_all[$past(rx_line)] == ST_I); // R6
  AST_RETRY_FROM_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsm_q == F_RETRY) |-> $past(rx_fire && rx_kind == RX_NACK)); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (!req_ready && !rx_ready)); // R14
endmodule

// File: tb/coh_line_agent_tb_top.sv
module coh_line_agent_tb_top;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
  localparam logic [2:0] T_RS = 3'd0, T_RX = 3'd1, T_UP = 3'd2, T_WB = 3'd3, T_IA = 3'd4;
  localparam logic [2:0] G_E = 3'd0, G_S = 3'd1, G_M = 3'd2, G_NK = 3'd3, G_IV = 3'd4, G_WA = 3'd5;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  line;
    logic [31:0] wdata;
    logic [2:0]  grant;
    logic [31:0] gdata;
    logic [2:0]  msg;
    logic [31:0] done;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{LD, 2'd0, 32'h0,         G_E, 32'hA0A0_0000, T_RS, 32'hA0A0_0000},
    '{LD, 2'd1, 32'h0,         G_S, 32'hB1B1_1111, T_RS, 32'hB1B1_1111},
    '{ST, 2'd2, 32'hC2C2_2222, G_E, 32'hDEAD_BEEF, T_RX, 32'hC2C2_2222},
    '{LD, 2'd3, 32'h0,         G_E, 32'hD3D3_3333, T_RS, 32'hD3D3_3333}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [1:0] req_op = '0, req_line = '0, rx_line = '0, tx_line;
  logic [31:0] req_wdata = '0, rx_data = '0, done_rdata, tx_data;
  logic [2:0] rx_type = '0, tx_type;
  logic [3:0] rx_txn = '0, tx_txn;
  logic req_ready, done_valid, tx_valid, rx_ready, proto_err;

  int n_chk = 0, n_fail = 0, done_cnt = 0, err_cnt = 0, done_mark = 0;
  logic [31:0] done_last = '0;
  logic [3:0] exp_txn = '0;

  always #10 clk = ~clk;

  coh_line_agent dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_line(req_line), .req_wdata(req_wdata),
    .done_valid(done_valid), .done_rdata(done_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_type(tx_type), .tx_line(tx_line), .tx_txn(tx_txn),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type),
    .rx_line(rx_line), .rx_txn(rx_txn), .rx_data(rx_data), .proto_err(proto_err));

  always @(posedge clk) begin
    if (done_valid) begin
      done_cnt  <= done_cnt + 1;
      done_last <= done_rdata;
    end
    if (proto_err) err_cnt <= err_cnt + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic core(input logic [1:0] op, input logic [1:0] line, input logic [31:0] d);
    req_valid = 1'b1; req_op = op; req_line = line; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rx(input logic [2:0] t, input logic [1:0] line, input logic [3:0] id, input logic [31:0] d);
    rx_valid = 1'b1; rx_type = t; rx_line = line; rx_txn = id; rx_data = d;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_tx(input string tag, input logic [2:0] t, input logic [1:0] line,
                           input logic [3:0] id, input logic [31:0] d);
    for (int w = 0; w < 20 && !tx_valid; w++) @(negedge clk);
    chk({tag, " tx_valid"}, tx_valid, 1);
    chk({tag, " tx_type"}, tx_type, t);
    chk({tag, " tx_line"}, tx_line, line);
    chk({tag, " tx_txn"}, tx_txn, id);
    chk({tag, " tx_data"}, tx_data, d);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic expect_done(input string tag, input logic [31:0] d);
    repeat (2) @(negedge clk);
    chk({tag, " done count"}, done_cnt, done_mark + 1);
    chk({tag, " done data"}, done_last, d);
    done_mark = done_cnt;
  endtask

  task automatic no_tx(input string tag);
    repeat (3) @(negedge clk);
    chk({tag, " no message"}, tx_valid, 0);
  endtask

  task automatic own_req(input string tag, input logic [2:0] t, input logic [1:0] line, input logic [31:0] d);
    expect_tx(tag, t, line, exp_txn, d);
    exp_txn = exp_txn + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 proto_err", proto_err, 0);
    @(negedge clk);

    // R2 R3 fills from all-Invalid lines
    for (int i = 0; i < 4; i++) begin
      core(VECS[i].op, VECS[i].line, VECS[i].wdata);
      own_req("R2 R3 fill request", VECS[i].msg, VECS[i].line, 32'h0);
      rx(VECS[i].grant, VECS[i].line, exp_txn - 1'b1, VECS[i].gdata);
      expect_done("R2 R3 fill", VECS[i].done);
    end
    core(LD, 2'd1, 0); expect_done("R2 shared hit", 32'hB1B1_1111); no_tx("R2 shared hit");
    core(LD, 2'd2, 0); expect_done("R3 store miss data", 32'hC2C2_2222); no_tx("R3 modified hit");

    // R4 silent upgrade on E and store on M
    core(ST, 2'd0, 32'h1111); expect_done("R4 store on E", 32'h1111); no_tx("R4 store on E");
    core(ST, 2'd2, 32'h2222); expect_done("R4 store on M", 32'h2222); no_tx("R4 store on M");
    core(LD, 2'd0, 0); expect_done("R4 readback", 32'h1111);

    // R5 upgrade from S
    core(ST, 2'd1, 32'h3333);
    own_req("R5 upgrade", T_UP, 2'd1, 0);
    rx(G_M, 2'd1, exp_txn - 1'b1, 32'hFFFF_FFFF);
    expect_done("R5 grantM", 32'h3333);
    core(LD, 2'd1, 0); expect_done("R5 line keeps store data", 32'h3333); no_tx("R5 hit");

    // R9 clean evict
    core(EV, 2'd3, 0); expect_done("R9 evict E", 0); no_tx("R9 evict E");
    core(LD, 2'd3, 0); own_req("R9 line now invalid", T_RS, 2'd3, 0);
    rx(G_S, 2'd3, exp_txn - 1'b1, 32'h44); expect_done("R9 refill", 32'h44);

    // R6 invalidate on S
    rx(G_IV, 2'd3, 4'd9, 0);
    expect_tx("R6 inv ack", T_IA, 2'd3, 4'd9, 0);
    core(LD, 2'd3, 0); own_req("R6 line invalid after inval", T_RS, 2'd3, 0);
    rx(G_E, 2'd3, exp_txn - 1'b1, 32'h55); expect_done("R6 refill", 32'h55);

    // R7 invalidate on M
    rx(G_IV, 2'd2, 4'd7, 0);
    expect_tx("R7 forced writeback", T_WB, 2'd2, 4'd7, 32'h2222);
    req_line = 2'd2; #1;
    chk("R7 request waits for ack", req_ready, 0);
    rx(G_WA, 2'd2, 4'd7, 0);
    repeat (2) @(negedge clk);
    chk("R7 no completion", done_cnt, done_mark);
    chk("R7 no error", err_cnt, 0);
    core(LD, 2'd2, 0); own_req("R7 line invalid after ack", T_RS, 2'd2, 0);
    rx(G_S, 2'd2, exp_txn - 1'b1, 32'h88); expect_done("R7 refill", 32'h88);

    // R8 evict M
    core(EV, 2'd0, 0);
    own_req("R8 eviction writeback", T_WB, 2'd0, 32'h1111);
    rx(G_WA, 2'd0, exp_txn - 1'b1, 0);
    expect_done("R8 evict done", 0);
    core(LD, 2'd0, 0); own_req("R8 line invalid", T_RS, 2'd0, 0);
    rx(G_E, 2'd0, exp_txn - 1'b1, 32'h99); expect_done("R8 refill", 32'h99);

    // R10 R11 upgrade, invalidation meanwhile, nack, retry
    core(ST, 2'd2, 32'h77);
    own_req("R10 upgrade", T_UP, 2'd2, 0);
    rx(G_IV, 2'd2, 4'd12, 0);
    expect_tx("R11 inv ack while pending", T_IA, 2'd2, 4'd12, 0);
    chk("R11 no completion yet", done_cnt, done_mark);
    rx(G_NK, 2'd2, exp_txn - 1'b1, 0);
    own_req("R10 retry read exclusive", T_RX, 2'd2, 0);
    rx(G_E, 2'd2, exp_txn - 1'b1, 32'h1234);
    expect_done("R10 retried store", 32'h77);
    core(LD, 2'd2, 0); expect_done("R10 line data", 32'h77); no_tx("R10 hit");

    // R13 unmatched grant while idle
    rx(G_S, 2'd1, exp_txn, 32'h5555);
    repeat (2) @(negedge clk);
    chk("R13 error pulse", err_cnt, 1);
    core(LD, 2'd1, 0); expect_done("R13 line untouched", 32'h3333); no_tx("R13 line untouched");

    // R14 back-pressure, plus R13 mismatch during a wait
    core(EV, 2'd1, 0);
    chk("R14 tx valid", tx_valid, 1);
    repeat (3) @(negedge clk);
    chk("R14 held valid", tx_valid, 1);
    chk("R14 held data", tx_data, 32'h3333);
    chk("R14 held type", tx_type, T_WB);
    req_line = 2'd3; #1;
    chk("R14 req_ready low", req_ready, 0);
    chk("R14 rx_ready low", rx_ready, 0);
    own_req("R14 writeback", T_WB, 2'd1, 32'h3333);
    rx(G_WA, 2'd1, exp_txn + 4'd3, 0);
    repeat (2) @(negedge clk);
    chk("R13 wrong id error", err_cnt, 2);
    chk("R13 wrong id no completion", done_cnt, done_mark);
    rx(G_WA, 2'd1, exp_txn - 1'b1, 0);
    expect_done("R14 writeback ack", 0);

    // R12 counter wrap
    core(EV, 2'd3, 0); expect_done("R12 prep evict", 0);
    for (int k = 0; k < 17; k++) begin
      core(LD, 2'd3, 0);
      own_req("R12 txn sequence", T_RS, 2'd3, 0);
      rx(G_S, 2'd3, exp_txn - 1'b1, k);
      expect_done("R12 fill", k);
      core(EV, 2'd3, 0);
      expect_done("R12 evict", 0);
    end
    chk("R13 no spurious errors", err_cnt, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule